// File: doc/BRIEF.md
# Six-Control ALU with Output Shifter

This block is the combinational arithmetic stage of a bus-based datapath. Operand A comes from a holding register and operand B from a source bus. The result goes through a small shifter onto a destination bus. Six control bits set the operation: a two-bit function code, separate gates that force each operand to zero, an inversion of the gated A operand, and a forced carry into the adder. The same function code gives bitwise AND, OR, complement of B, or a sum.

Two further bits act on the ALU output. One shifts it left by one byte and the other shifts it right by one bit while keeping the sign. Two status flags, negative and zero, are taken from the ALU output before the shifter, so a branch can test the value that was computed whatever shift is applied. The block holds no state. Every output is a function of the present inputs only.

Top module: `alu_shift_datapath`

## Requirements
- R1: `func_sel` selects the operation, with `func_sel[1]` as the first code bit and `func_sel[0]` as the second: 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives NOT B (A is ignored), and 2'b11 gives A + B.
- R2: When `ena_a` is 0, operand A is replaced by zero before inversion. When `ena_b` is 0, operand B is replaced by zero.
- R3: When `inv_a` is 1, the gated A operand is bitwise complemented before the function is applied.
- R4: `carry_in` feeds a carry into bit 0 of the adder, so the sum is A + B + 1 modulo 2^WIDTH. It has no effect on the three logic functions.
- R5: When only `shl_byte` is 1, `c_out` is the ALU result shifted left by 8 bits, with the low 8 bits set to zero.
- R6: When only `shr_arith` is 1, `c_out` is the ALU result shifted right by 1 bit, with bit WIDTH-1 copied from the ALU result's own bit WIDTH-1.
- R7: When both shift controls are 1, or both are 0, `c_out` equals the ALU result unshifted.
- R8: `flag_neg` equals bit WIDTH-1 of the ALU result before shifting. `flag_zero` is 1 exactly when that pre-shift result is all zeros.
- R9: The add function with `ena_a`=0, `ena_b`=0, `inv_a`=1 gives all ones when `carry_in`=0 and gives zero when `carry_in`=1.
- R10: The block is purely combinational. All outputs reflect a new input set in the same cycle, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_hold | input | WIDTH | Operand A from the holding register |
| opb_bus | input | WIDTH | Operand B from the source bus |
| func_sel | input | 2 | Function code ([1] first bit, [0] second bit) |
| ena_a | input | 1 | Pass operand A (0 forces zero) |
| ena_b | input | 1 | Pass operand B (0 forces zero) |
| inv_a | input | 1 | Complement the gated A operand |
| carry_in | input | 1 | Forced carry into bit 0 of the adder |
| shl_byte | input | 1 | Shift the result left by one byte |
| shr_arith | input | 1 | Shift the result right by one bit, keeping the sign |
| c_out | output | WIDTH | Shifted result onto the destination bus |
| flag_neg | output | 1 | Sign bit of the pre-shift result |
| flag_zero | output | 1 | Pre-shift result is zero |

## Verification
Every result of this block, including the shifted bus value and both flags, is due zero cycles after its inputs change, because no path has a register. The bench therefore changes inputs just after a rising edge and reads all three outputs at the following falling edge, half a period later. At that point the settled combinational value is observed and no edge ordering is involved. The sweep covers every one of the 64 ALU control words under all four shift settings for eight operand pairs, and a separate set of checks covers the fixed-constant combinations.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_NOTB = 2'b10,
      FN_ADD  = 2'b11
   } alu_fn_e;

   typedef enum logic [1:0] {
      SH_NONE,
      SH_LEFT,
      SH_RIGHT
   } shift_mode_e;

   function automatic shift_mode_e decode_shift(input logic left, input logic right);
      if (left && !right)
         return SH_LEFT;
      else if (right && !left)
         return SH_RIGHT;
      else
         return SH_NONE;
   endfunction

endpackage

// File: rtl/alu_operand_gate.sv
module alu_operand_gate #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opa_raw,
   input  logic [WIDTH-1:0] opb_raw,
   input  logic             ena_a,
   input  logic             ena_b,
   input  logic             inv_a,
   output logic [WIDTH-1:0] opa_eff,
   output logic [WIDTH-1:0] opb_eff
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_operand_gate: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] opa_gated;

   always_comb begin
      opa_gated = ena_a ? opa_raw : '0;
      opa_eff   = inv_a ? ~opa_gated : opa_gated;
      opb_eff   = ena_b ? opb_raw : '0;
   end

   // R2 / R3: a disabled, uninverted A operand reaches the function unit as zero
   always_comb begin
      if (!$isunknown({ena_a, inv_a}) && !ena_a && !inv_a)
         assert_gated_a_zero_R2: assert (opa_eff == '0);
      if (!$isunknown({ena_a, inv_a}) && !ena_a && inv_a)
         assert_inverted_zero_R3: assert (&opa_eff);
   end

endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
   import alu_ctl_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [1:0]       func_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_func_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] sum;

   generate
      if (RIPPLE_ADDER) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = carry_in;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = opa[i] ^ opb[i] ^ carry[i];
            assign carry[i+1] = (opa[i] & opb[i]) | (carry[i] & (opa[i] ^ opb[i]));
         end
      end else begin : g_behav
         always_comb sum = opa + opb + WIDTH'(carry_in);
      end
   endgenerate

   alu_fn_e fn;
   assign fn = alu_fn_e'(func_sel);

   always_comb begin
      unique case (fn)
         FN_AND:  result = opa & opb;
         FN_OR:   result = opa | opb;
         FN_NOTB: result = ~opb;
         FN_ADD:  result = sum;
         default: result = '0;
      endcase
   end

   // R1: complement of a zero B operand is all ones
   always_comb begin
      if (!$isunknown({func_sel, opb}) && fn == FN_NOTB && opb == '0)
         assert_notb_ones_R1: assert (&result);
      // R4: carry alone onto zero operands yields one
      if (!$isunknown({func_sel, opa, opb, carry_in}) && fn == FN_ADD &&
          opa == '0 && opb == '0)
         assert_carry_one_R4: assert (result == WIDTH'(carry_in));
   end

endmodule

// File: rtl/alu_out_shifter.sv
module alu_out_shifter
   import alu_ctl_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int LEFT_SHIFT = 8
) (
   input  logic [WIDTH-1:0] din,
   input  logic             shl_byte,
   input  logic             shr_arith,
   output logic [WIDTH-1:0] dout
);

   generate
      if (LEFT_SHIFT < 1 || LEFT_SHIFT >= WIDTH) begin : g_bad_shift
         $error("alu_out_shifter: LEFT_SHIFT must be in 1..WIDTH-1");
      end
   endgenerate

   shift_mode_e mode;
   logic [WIDTH-1:0] left_v;
   logic [WIDTH-1:0] right_v;

   always_comb begin
      mode    = decode_shift(shl_byte, shr_arith);
      left_v  = {din[WIDTH-LEFT_SHIFT-1:0], {LEFT_SHIFT{1'b0}}};
      right_v = {din[WIDTH-1], din[WIDTH-1:1]};
      unique case (mode)
         SH_LEFT:  dout = left_v;
         SH_RIGHT: dout = right_v;
         default:  dout = din;
      endcase
   end

   always_comb begin
      if (!$isunknown({shl_byte, shr_arith, din})) begin
         // R7: illegal pair leaves the word untouched
         if (shl_byte && shr_arith)
            assert_both_pass_R7: assert (dout == din);
         // R5: low byte cleared on left shift
         if (shl_byte && !shr_arith)
            assert_left_fill_R5: assert (dout[LEFT_SHIFT-1:0] == '0);
         // R6: sign preserved on right shift
         if (shr_arith && !shl_byte)
            assert_sign_keep_R6: assert (dout[WIDTH-1] == din[WIDTH-1]);
      end
   end

endmodule

// File: rtl/alu_shift_datapath.sv
module alu_shift_datapath #(
   parameter int WIDTH        = 32,
   parameter int LEFT_SHIFT   = 8,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic [WIDTH-1:0] opa_hold,
   input  logic [WIDTH-1:0] opb_bus,
   input  logic [1:0]       func_sel,
   input  logic             ena_a,
   input  logic             ena_b,
   input  logic             inv_a,
   input  logic             carry_in,
   input  logic             shl_byte,
   input  logic             shr_arith,
   output logic [WIDTH-1:0] c_out,
   output logic             flag_neg,
   output logic             flag_zero
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] opa_eff;
   logic [WIDTH-1:0] opb_eff;
   logic [WIDTH-1:0] alu_res;

   alu_operand_gate #(.WIDTH(WIDTH)) u_gate (
      .opa_raw (opa_hold),
      .opb_raw (opb_bus),
      .ena_a   (ena_a),
      .ena_b   (ena_b),
      .inv_a   (inv_a),
      .opa_eff (opa_eff),
      .opb_eff (opb_eff)
   );

   alu_func_unit #(.WIDTH(WIDTH), .RIPPLE_ADDER(RIPPLE_ADDER)) u_func (
      .opa      (opa_eff),
      .opb      (opb_eff),
      .func_sel (func_sel),
      .carry_in (carry_in),
      .result   (alu_res)
   );

   alu_out_shifter #(.WIDTH(WIDTH), .LEFT_SHIFT(LEFT_SHIFT)) u_shift (
      .din       (alu_res),
      .shl_byte  (shl_byte),
      .shr_arith (shr_arith),
      .dout      (c_out)
   );

   assign flag_neg  = alu_res[MSB];
   assign flag_zero = (alu_res == '0);

   always_comb begin
      if (!$isunknown({opa_hold, opb_bus, func_sel, ena_a, ena_b, inv_a,
                       carry_in, shl_byte, shr_arith})) begin
         // R8: a zero pre-shift value stays zero through any shift
         if (flag_zero)
            assert_zero_out_R8: assert (c_out == '0);
         // R8: right shift keeps the sign that the flag reports
         if (shr_arith && !shl_byte)
            assert_neg_sign_R8: assert (c_out[MSB] == flag_neg);
         // R9: all-ones constant
         if (func_sel == 2'b11 && !ena_a && !ena_b && inv_a && !carry_in)
            assert_minus_one_R9: assert (flag_neg && !flag_zero);
         // R9: wrap to zero
         if (func_sel == 2'b11 && !ena_a && !ena_b && inv_a && carry_in)
            assert_wrap_zero_R9: assert (flag_zero);
      end
   end

endmodule

// File: tb/test_alu_shift_datapath.sv
module test_alu_shift_datapath;

   localparam int W = 32;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0] opa_hold, opb_bus;
   logic [1:0]   func_sel;
   logic         ena_a, ena_b, inv_a, carry_in, shl_byte, shr_arith;
   logic [W-1:0] c_out;
   logic         flag_neg, flag_zero;

   int n_checks = 0;
   int n_bad    = 0;
   bit finished = 1'b0;

   alu_shift_datapath i_alu_shift_datapath (
      .opa_hold, .opb_bus, .func_sel, .ena_a, .ena_b, .inv_a,
      .carry_in, .shl_byte, .shr_arith, .c_out, .flag_neg, .flag_zero
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pat_a(input int i);
      case (i)
         0: return 32'h0000_0000;  1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;  3: return 32'h1234_5678;
         4: return 32'h0000_0001;  5: return 32'hA5A5_A5A5;
         6: return 32'h7FFF_FFFF;  default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [W-1:0] pat_b(input int i);
      case (i)
         0: return 32'h0000_0000;  1: return 32'h0000_0001;
         2: return 32'h7FFF_FFFF;  3: return 32'h9ABC_DEF0;
         4: return 32'hFFFF_FFFF;  5: return 32'h5A5A_5A5A;
         6: return 32'h7FFF_FFFF;  default: return 32'h8000_0000;
      endcase
   endfunction

   // Reference from the requirements (R1..R4)
   function automatic logic [W-1:0] ref_alu(input logic [W-1:0] a_in, input logic [W-1:0] b_in,
                                           input logic [5:0] ctl);
      logic [W-1:0] a, b;
      logic [1:0] fn;
      fn = ctl[5:4];
      a  = ctl[3] ? a_in : '0;
      b  = ctl[2] ? b_in : '0;
      if (ctl[1]) a = ~a;
      case (fn)
         2'b00:   return a & b;
         2'b01:   return a | b;
         2'b10:   return ~b;
         default: return W'(({1'b0, a} + {1'b0, b} + (W+1)'(ctl[0])) & {1'b0, {W{1'b1}}});
      endcase
   endfunction

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [5:0] ctl, input logic [1:0] sh);
      @(posedge clk);
      #1;
      opa_hold = a; opb_bus = b;
      func_sel = ctl[5:4]; ena_a = ctl[3]; ena_b = ctl[2];
      inv_a = ctl[1]; carry_in = ctl[0];
      shl_byte = sh[1]; shr_arith = sh[0];
      @(negedge clk);
   endtask

   initial begin : main
      opa_hold = '0; opb_bus = '0; func_sel = 2'b00;
      ena_a = 0; ena_b = 0; inv_a = 0; carry_in = 0; shl_byte = 0; shr_arith = 0;
      @(negedge clk);
      // R10: quiet inputs give zero result immediately
      check("R10 idle out", c_out, '0);
      check("R8 idle zero flag", W'(flag_zero), W'(1));

      // Fixed constants, R9
      apply(32'h1357_9BDF, 32'h2468_ACE0, 6'b11_0010, 2'b00);
      check("R9 minus one", c_out, '1);
      check("R9 minus one neg", W'(flag_neg), W'(1));
      apply(32'h1357_9BDF, 32'h2468_ACE0, 6'b11_0011, 2'b00);
      check("R9 wrap zero", c_out, '0);
      check("R9 wrap zero flag", W'(flag_zero), W'(1));
      // R4: carry ignored by logic functions
      apply(32'hF0F0_0000, 32'h0F0F_0000, 6'b00_1101, 2'b00);
      check("R4 carry ignored AND", c_out, 32'h0000_0000);
      apply(32'hF0F0_0000, 32'h0F0F_0000, 6'b01_1101, 2'b00);
      check("R4 carry ignored OR", c_out, 32'hFFFF_0000);
      // R3: inverted A plus B plus 1 is B - A
      apply(32'd5, 32'd12, 6'b11_1111, 2'b00);
      check("R3 subtract", c_out, 32'd7);
      // R6 sign copy, R5 fill
      apply(32'h8000_0010, 32'h0, 6'b01_1000, 2'b01);
      check("R6 sra negative", c_out, 32'hC000_0008);
      apply(32'h1234_5678, 32'h0, 6'b01_1000, 2'b10);
      check("R5 sll byte", c_out, 32'h3456_7800);
      apply(32'h1234_5678, 32'h0, 6'b01_1000, 2'b11);
      check("R7 both set", c_out, 32'h1234_5678);

      // Sweep: every control word, every shift setting, eight operand pairs
      for (int p = 0; p < 8; p++) begin
         for (int c = 0; c < 64; c++) begin
            for (int s = 0; s < 4; s++) begin
               logic [W-1:0] r, e;
               string tag;
               r = ref_alu(pat_a(p), pat_b(p), 6'(c));
               case (s)
                  2: begin e = r << 8;             tag = "R5 sweep";    end
                  1: begin e = {r[W-1], r[W-1:1]}; tag = "R6 sweep";    end
                  3: begin e = r;                  tag = "R7 sweep";    end
                  default: begin e = r;            tag = "R1 R2 sweep"; end
               endcase
               apply(pat_a(p), pat_b(p), 6'(c), 2'(s));
               check(tag, c_out, e);
               check("R8 neg sweep", W'(flag_neg), W'(r[W-1]));
               check("R8 zero sweep", W'(flag_zero), W'(r == '0));
            end
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

endmodule